// File: doc/BRIEF.md
# Staged Low/High Clock Divider

This block divides its input clock into a square-or-skewed waveform. Each period is a low phase followed by a high phase, and each phase lasts a programmed number of input cycles. The two counts are held in 4-bit fields. The same waveform drives every bit of a multi-bit output, so all downstream clocks share one setting.

Software does not change the running waveform directly. A low-count write only fills a holding register. A high-count write fills its own holding register and arms a commit. The armed pair takes effect when the high phase that is running ends, so a period is never cut short. Software may write both counts in one cycle, or it may write the low count first and the high count last. A busy flag stays up from the high-count write until the pair is in use. The counts in use can be read back on two ports.

Top module: `staged_clock_divider`

## Requirements
- R1: After reset the output bits are 0, busy is 0, and the applied low and high counts equal the parameters LO_RST and HI_RST (2 and 2 by default).
- R2: The output stays 0 for the applied low count and then stays 1 for the applied high count, in input cycles. This repeats, and every period starts with its low phase.
- R3: An applied count of 0 behaves as a count of 1.
- R4: A low-count write without a high-count write changes neither the applied counts nor the waveform, and it leaves busy at 0.
- R5: A high-count write raises busy in the cycle after the write. Busy falls in the same cycle that the applied counts take the staged values.
- R6: The applied counts change only on the edge where the output goes from 1 to 0. A high phase that is running when the write arrives finishes with its old length.
- R7: All NUM_OUT output bits are equal in every cycle.
- R8: If the high count is written again while busy, the most recent staged pair is the one applied. If that write falls on the edge where a commit takes place, busy stays 1 and the newer pair is applied at the following 1-to-0 edge.
- R9: A low-count write in the same cycle as a high-count write is part of the pair that is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rstN | input | 1 | Asynchronous reset, active low |
| wrLo | input | 1 | Strobe that stages the low count |
| wrLoData | input | 4 | Low count (input cycles at 0) |
| wrHi | input | 1 | Strobe that stages the high count and arms a commit |
| wrHiData | input | 4 | High count (input cycles at 1) |
| divClk | output | NUM_OUT | Divided output, all bits identical |
| busy | output | 1 | A staged pair is waiting for the next period boundary |
| activeLo | output | 4 | Low count in use |
| activeHi | output | 4 | High count in use |

## Verification
A cycle-accurate reference model runs beside the design and predicts the output, busy and the applied counts. It is driven through several patterns: a low-count write on its own, which must change nothing; a combined write of both counts in one cycle; zero counts, which must give the shortest period; and back-to-back high-count writes during the short period, so that one of them is certain to land on a commit edge. One further case arms a commit early in a long high phase. That high phase must keep its old length, which separates a commit at the period boundary from a commit made at once. The low and high run lengths are also measured directly at the output.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  parameter int CNT_W = 4;

  // Control-to-datapath strobes: commit pulse plus the staged pair.
  typedef struct packed {
    logic             commit;
    logic [CNT_W-1:0] lo;
    logic [CNT_W-1:0] hi;
  } cfgStrobe_t;
endpackage

// File: rtl/sdiv_ctrl.sv
module sdiv_ctrl
  import sdiv_pkg::*;
#(
  parameter int LO_RST = 2,
  parameter int HI_RST = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrLo,
  input  logic [CNT_W-1:0] wrLoData,
  input  logic             wrHi,
  input  logic [CNT_W-1:0] wrHiData,
  input  logic             boundary,
  output cfgStrobe_t       strobe,
  output logic             busy
);
  logic [CNT_W-1:0] stagedLoQ;
  logic [CNT_W-1:0] stagedHiQ;
  logic             pendingQ;
  logic             commit;

  assign commit = pendingQ & boundary;

  always_comb begin
    strobe.commit = commit;
    strobe.lo     = stagedLoQ;
    strobe.hi     = stagedHiQ;
  end

  assign busy = pendingQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stagedLoQ <= CNT_W'(LO_RST);
      stagedHiQ <= CNT_W'(HI_RST);
      pendingQ  <= 1'b0;
    end else begin
      if (wrLo) stagedLoQ <= wrLoData;
      if (wrHi) begin
        stagedHiQ <= wrHiData;
        pendingQ  <= 1'b1;   // a new arm wins over a commit on the same edge
      end else if (commit) begin
        pendingQ  <= 1'b0;
      end
    end
  end

  assert_hi_write_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    wrHi |=> busy);

  assert_busy_holds_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !boundary) |=> busy);

  assert_lo_only_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && wrLo && !wrHi) |=> !busy);

  assert_rearm_on_commit_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && boundary && wrHi) |=> busy);
endmodule

// File: rtl/sdiv_datapath.sv
module sdiv_datapath
  import sdiv_pkg::*;
#(
  parameter int NUM_OUT = 2,
  parameter int LO_RST  = 2,
  parameter int HI_RST  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  cfgStrobe_t         strobe,
  output logic               boundary,
  output logic [NUM_OUT-1:0] divClk,
  output logic [CNT_W-1:0]   activeLo,
  output logic [CNT_W-1:0]   activeHi
);
  logic [CNT_W-1:0] actLoQ;
  logic [CNT_W-1:0] actHiQ;
  logic [CNT_W-1:0] cntQ;
  logic             phaseQ;   // 0 = low phase, 1 = high phase
  logic [CNT_W-1:0] effLo;
  logic [CNT_W-1:0] effHi;
  logic [CNT_W-1:0] lastLo;
  logic [CNT_W-1:0] lastHi;

  // A zero count is stretched to one cycle.
  assign effLo  = (actLoQ == '0) ? CNT_W'(1) : actLoQ;
  assign effHi  = (actHiQ == '0) ? CNT_W'(1) : actHiQ;
  assign lastLo = effLo - CNT_W'(1);
  assign lastHi = effHi - CNT_W'(1);

  assign boundary = phaseQ && (cntQ == lastHi);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= 1'b0;
      cntQ   <= '0;
      actLoQ <= CNT_W'(LO_RST);
      actHiQ <= CNT_W'(HI_RST);
    end else if (!phaseQ) begin
      if (cntQ == lastLo) begin
        phaseQ <= 1'b1;
        cntQ   <= '0;
      end else begin
        cntQ <= cntQ + CNT_W'(1);
      end
    end else if (boundary) begin
      phaseQ <= 1'b0;
      cntQ   <= '0;
      if (strobe.commit) begin
        actLoQ <= strobe.lo;
        actHiQ <= strobe.hi;
      end
    end else begin
      cntQ <= cntQ + CNT_W'(1);
    end
  end

  generate
    for (genvar g = 0; g < NUM_OUT; g++) begin : gOut
      assign divClk[g] = phaseQ;
    end
  endgenerate

  assign activeLo = actLoQ;
  assign activeHi = actHiQ;

  assert_apply_at_boundary_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({actLoQ, actHiQ}) |-> $fell(phaseQ));

  assert_low_count_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    !phaseQ |-> (cntQ < effLo));

  assert_high_count_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    phaseQ |-> (cntQ < effHi));

  assert_short_high_R3: assert property (@(posedge clk) disable iff (!rstN)
    (phaseQ && actHiQ <= CNT_W'(1)) |=> !phaseQ);

  assert_short_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!phaseQ && actLoQ <= CNT_W'(1)) |=> phaseQ);
endmodule

// File: rtl/staged_clock_divider.sv
module staged_clock_divider
  import sdiv_pkg::*;
#(
  parameter int NUM_OUT = 2,
  parameter int LO_RST  = 2,
  parameter int HI_RST  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrLo,
  input  logic [3:0]         wrLoData,
  input  logic               wrHi,
  input  logic [3:0]         wrHiData,
  output logic [NUM_OUT-1:0] divClk,
  output logic               busy,
  output logic [3:0]         activeLo,
  output logic [3:0]         activeHi
);
  cfgStrobe_t strobe;
  logic       boundary;

  sdiv_ctrl #(.LO_RST(LO_RST), .HI_RST(HI_RST)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrLo     (wrLo),
    .wrLoData (wrLoData),
    .wrHi     (wrHi),
    .wrHiData (wrHiData),
    .boundary (boundary),
    .strobe   (strobe),
    .busy     (busy)
  );

  sdiv_datapath #(.NUM_OUT(NUM_OUT), .LO_RST(LO_RST), .HI_RST(HI_RST)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .boundary (boundary),
    .divClk   (divClk),
    .activeLo (activeLo),
    .activeHi (activeHi)
  );

  assert_outputs_match_R7: assert property (@(posedge clk) disable iff (!rstN)
    (divClk == {NUM_OUT{divClk[0]}}));
endmodule

// File: tb/staged_clock_divider_tb.sv
module staged_clock_divider_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrLo = 1'b0;
  logic [3:0] wrLoData = '0;
  logic       wrHi = 1'b0;
  logic [3:0] wrHiData = '0;
  logic [1:0] divClk;
  logic       busy;
  logic [3:0] activeLo;
  logic [3:0] activeHi;

  int vectors = 0;
  int miscompares = 0;

  staged_clock_divider #(.NUM_OUT(2), .LO_RST(2), .HI_RST(2)) u_dut (
    .clk(clk), .rstN(rstN), .wrLo(wrLo), .wrLoData(wrLoData),
    .wrHi(wrHi), .wrHiData(wrHiData), .divClk(divClk), .busy(busy),
    .activeLo(activeLo), .activeHi(activeHi)
  );

  always #2 clk = ~clk;   // 250 MHz

  typedef struct packed {
    logic       level;
    logic       busy;
    logic [3:0] lo;
    logic [3:0] hi;
  } expItem_t;

  expItem_t expQ[$];

  // Reference model built from the requirements; pushes one item per edge.
  int mPhase, mCnt, mLo, mHi, mStLo, mStHi, mPend;
  always @(posedge clk) begin
    int eLo, eHi;
    if (!rstN) begin
      mPhase = 0; mCnt = 0; mLo = 2; mHi = 2; mStLo = 2; mStHi = 2; mPend = 0;
    end else begin
      eLo = (mLo == 0) ? 1 : mLo;
      eHi = (mHi == 0) ? 1 : mHi;
      if (mPhase == 0) begin
        if (mCnt == eLo - 1) begin mPhase = 1; mCnt = 0; end
        else mCnt++;
      end else if (mCnt == eHi - 1) begin
        mPhase = 0; mCnt = 0;
        if (mPend != 0) begin mLo = mStLo; mHi = mStHi; mPend = 0; end
      end else mCnt++;
      if (wrLo) mStLo = wrLoData;
      if (wrHi) begin mStHi = wrHiData; mPend = 1; end
    end
    expQ.push_back('{level: mPhase[0], busy: mPend[0], lo: mLo[3:0], hi: mHi[3:0]});
  end

  // Monitor: pops and compares away from the active edge.
  always @(negedge clk) begin
    expItem_t e;
    if (expQ.size() > 0) begin
      e = expQ.pop_front();
      vectors++;
      if (divClk[0] !== e.level) begin
        miscompares++;
        $display("FAIL R2 divClk actual=%b expected=%b", divClk[0], e.level);
      end
      if (divClk[1] !== divClk[0]) begin
        miscompares++;
        $display("FAIL R7 divClk[1] actual=%b expected=%b", divClk[1], divClk[0]);
      end
      if (busy !== e.busy) begin
        miscompares++;
        $display("FAIL R5 busy actual=%b expected=%b", busy, e.busy);
      end
      if (activeLo !== e.lo || activeHi !== e.hi) begin
        miscompares++;
        $display("FAIL R6 applied actual=%0d/%0d expected=%0d/%0d",
                 activeLo, activeHi, e.lo, e.hi);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doWrite(input bit dl, input logic [3:0] lo, input bit dh, input logic [3:0] hi);
    @(negedge clk); #1;
    wrLo = dl; wrLoData = lo; wrHi = dh; wrHiData = hi;
    @(negedge clk); #1;
    wrLo = 1'b0; wrHi = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  task automatic waitRise();
    logic prev;
    @(negedge clk);
    prev = divClk[0];
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!prev && divClk[0]) break;
      prev = divClk[0];
    end
  endtask

  // After waitRise: count the high run including the current sample, then the low run.
  task automatic measureRuns(output int hiLen, output int loLen);
    hiLen = 1; loLen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!divClk[0]) break;
      hiLen++;
    end
    loLen = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (divClk[0]) break;
      loLen++;
    end
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog R5 actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int h, l;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(divClk === 2'b00, "R1 divClk", divClk, 0);
    check(busy === 1'b0, "R1 busy", busy, 0);
    check(activeLo === 4'd2, "R1 activeLo", activeLo, 2);
    check(activeHi === 4'd2, "R1 activeHi", activeHi, 2);
    #1 rstN = 1'b1;

    // R2: default 2/2 waveform
    waitRise();
    measureRuns(h, l);
    check(h == 2, "R2 default high run", h, 2);
    check(l == 2, "R2 default low run", l, 2);

    // R4: low-only write is held back
    doWrite(1, 4'd5, 0, 4'd0);
    repeat (10) @(negedge clk);
    check(activeLo === 4'd2, "R4 activeLo after low-only write", activeLo, 2);
    check(busy === 1'b0, "R4 busy after low-only write", busy, 0);

    // R9: both counts in one cycle
    doWrite(1, 4'd3, 1, 4'd1);
    check(busy === 1'b1, "R5 busy after high write", busy, 1);
    waitIdle();
    check(activeLo === 4'd3 && activeHi === 4'd1, "R9 pair applied lo", activeLo, 3);
    waitRise();
    measureRuns(h, l);
    check(h == 1, "R9 high run", h, 1);
    check(l == 3, "R9 low run", l, 3);

    // R3: zero counts act as one
    doWrite(1, 4'd0, 0, 4'd0);
    doWrite(0, 4'd0, 1, 4'd0);
    waitIdle();
    waitRise();
    measureRuns(h, l);
    check(h == 1, "R3 high run", h, 1);
    check(l == 1, "R3 low run", l, 1);

    // R8: back-to-back high writes in the 1/1 period; latest pair wins
    @(negedge clk); #1;
    wrLo = 1; wrLoData = 4'd2; wrHi = 1; wrHiData = 4'd3;
    @(negedge clk); #1;
    wrLo = 1; wrLoData = 4'd4; wrHi = 1; wrHiData = 4'd5;
    @(negedge clk); #1;
    wrLo = 0; wrHi = 0;
    waitIdle();
    check(activeLo === 4'd4, "R8 latest lo", activeLo, 4);
    check(activeHi === 4'd5, "R8 latest hi", activeHi, 5);

    // R6: commit armed early in a 6-cycle high phase
    doWrite(1, 4'd2, 1, 4'd6);
    waitIdle();
    waitRise();
    #1;
    wrLo = 1; wrLoData = 4'd1; wrHi = 1; wrHiData = 4'd1;
    @(negedge clk);
    h = divClk[0] ? 2 : 1;
    #1 wrLo = 0; wrHi = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!divClk[0]) break;
      h++;
    end
    check(h == 6, "R6 running high phase keeps old length", h, 6);
    check(activeLo === 4'd1, "R6 new lo applied at 1-to-0 edge", activeLo, 1);
    check(busy === 1'b0, "R5 busy cleared with commit", busy, 0);
    @(negedge clk);
    check(divClk[0] === 1'b1, "R6 new low run of one", divClk[0], 1);

    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule